// File: doc/BRIEF.md
# Dead-Band Generator with Synchronized Delay Update

This block turns one PWM waveform into a complementary pair of outputs that are never high together. The primary output follows the input but holds back each rising edge by a programmable rise delay. The complementary output follows the inverted input and holds back each of its rising edges, which are the input's falling edges, by a programmable fall delay. Both delays are 12-bit cycle counts. A pulse that is no longer than its delay produces no output pulse at all. When the generator is disabled, the outputs are the plain input and its inverse, and the delay values have no effect.

Delay values arrive through a one-word write port. Each delay has its own 2-bit update policy. In the immediate policy a write takes effect at once. In the local policy the value waits in a shadow register until the next counter-zero strobe. In the global policy it also waits for a counter-zero strobe, but only for one that comes after a global update request. The PWM counter lives outside this block and supplies the counter-zero strobe.

Top module: `deadband_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, both outputs are low, both active delays are 0, no shadow value is pending and no global request is armed.
- R2: With `enable` low, `pwm_a_out` equals `pwm_in` from one clock earlier and `pwm_b_out` equals its inverse. The delay values are ignored.
- R3: With `enable` high and both delays 0, the outputs behave the same as in R2.
- R4: With `enable` high, when `pwm_in` is sampled high on edges k, k+1, and so on, `pwm_a_out` goes high after edge k+D, where D is the active rise delay. It goes low after the first edge that samples `pwm_in` low.
- R5: With `enable` high, `pwm_b_out` behaves as in R4 for the low periods of `pwm_in`, using the active fall delay.
- R6: A high period of L samples with L <= rise delay gives no high on `pwm_a_out`. A low period of L <= fall delay gives no high on `pwm_b_out`.
- R7: `pwm_a_out` and `pwm_b_out` are never high in the same cycle.
- R8: `wr_sel` = 0 writes the rise delay and `wr_sel` = 1 writes the fall delay. A policy code of 00 or 01 is immediate: the written value becomes active after the write edge and drops any pending shadow value.
- R9: Policy 10 (local): a write goes to the shadow register and marks it pending. The value becomes active at the next edge where `zero_strobe` is high. A second write before that edge replaces the pending value.
- R10: Policy 11 (global): a `global_req` pulse arms a request that is shared by both channels. A pending value transfers only at a `zero_strobe` edge while the request is armed. Any `zero_strobe` edge clears the armed request, but a request on that same edge re-arms it.
- R11: When a synchronized write and a transfer edge fall on the same cycle, the value that was already pending is transferred and the new value stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Dead-band enable; low gives the plain complementary outputs |
| pwm_in | input | 1 | Source PWM waveform |
| zero_strobe | input | 1 | One-cycle pulse when the PWM counter reaches zero |
| global_req | input | 1 | Global update request pulse |
| wr_en | input | 1 | Delay write strobe |
| wr_sel | input | 1 | 0 selects the rise delay, 1 selects the fall delay |
| wr_data | input | 12 | Delay value in clock cycles |
| rise_mode | input | 2 | Update policy for the rise delay |
| fall_mode | input | 2 | Update policy for the fall delay |
| pwm_a_out | output | 1 | Primary output, rising edge delayed |
| pwm_b_out | output | 1 | Complementary output, rising edge delayed |

## Verification
The assertions assume that `rst_n` is released away from a clock edge and that `rise_mode` and `fall_mode` stay at their values for the cycle in which a write is applied. The stability properties decode the policy from the sampled mode. The stimulus changes every input only on falling clock edges, and it changes a channel's policy only between writes. The bench holds each PWM pattern long enough for each case to settle, including delays both shorter and longer than the pulses.

// File: rtl/db_pkg.sv
package db_pkg;

    typedef enum logic [1:0] {
        UPD_IMM     = 2'b00,
        UPD_IMM_ALT = 2'b01,
        UPD_LOCAL   = 2'b10,
        UPD_GLOBAL  = 2'b11
    } upd_mode_e;

    localparam int NUM_CH = 2;

    function automatic logic mode_is_sync(upd_mode_e m);
        return (m == UPD_LOCAL) || (m == UPD_GLOBAL);
    endfunction

endpackage

// File: rtl/db_update_ctl.sv
module db_update_ctl
    import db_pkg::*;
#(
    parameter int DLY_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DLY_W-1:0] wr_data,
    input  logic [1:0]       mode,
    input  logic             zero_strobe,
    input  logic             armed,
    output logic [DLY_W-1:0] act_dly
);

    typedef struct packed {
        logic [DLY_W-1:0] act;
        logic [DLY_W-1:0] shadow;
        logic             pending;
    } upd_st_t;

    upd_st_t   st_d, st_q;
    upd_mode_e mode_e;
    logic      xfer;

    assign mode_e = upd_mode_e'(mode);

    always_comb begin
        st_d = st_q;
        xfer = zero_strobe && st_q.pending &&
               ((mode_e == UPD_LOCAL) || ((mode_e == UPD_GLOBAL) && armed));
        if (xfer) begin
            st_d.act     = st_q.shadow;
            st_d.pending = 1'b0;
        end
        if (wr_en) begin
            if (mode_is_sync(mode_e)) begin
                st_d.shadow  = wr_data;
                st_d.pending = 1'b1;
            end else begin
                st_d.act     = wr_data;
                st_d.shadow  = wr_data;
                st_d.pending = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_dly = st_q.act;

endmodule

// File: rtl/db_global_arm.sv
module db_global_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic global_req,
    input  logic zero_strobe,
    output logic armed
);

    logic armed_d, armed_q;

    always_comb begin
        armed_d = global_req || (armed_q && !zero_strobe);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= armed_d;
        end
    end

    assign armed = armed_q;

endmodule

// File: rtl/db_edge_path.sv
module db_edge_path #(
    parameter int DLY_W       = 12,
    parameter bit ACTIVE_HIGH = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             pwm_in,
    input  logic [DLY_W-1:0] dly,
    output logic             out
);

    localparam logic [DLY_W-1:0] RUN_MAX = '1;

    typedef struct packed {
        logic [DLY_W-1:0] run;
        logic             out;
    } path_st_t;

    path_st_t st_d, st_q;
    logic     src;

    always_comb begin
        src = ACTIVE_HIGH ? pwm_in : !pwm_in;
        st_d = st_q;
        if (src) begin
            st_d.run = (st_q.run == RUN_MAX) ? RUN_MAX : st_q.run + 1'b1;
        end else begin
            st_d.run = '0;
        end
        if (enable) begin
            st_d.out = src && (st_q.run >= dly);
        end else begin
            st_d.out = src;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out = st_q.out;

endmodule

// File: rtl/deadband_gen.sv
module deadband_gen
    import db_pkg::*;
#(
    parameter int DLY_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             pwm_in,
    input  logic             zero_strobe,
    input  logic             global_req,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [DLY_W-1:0] wr_data,
    input  logic [1:0]       rise_mode,
    input  logic [1:0]       fall_mode,
    output logic             pwm_a_out,
    output logic             pwm_b_out
);

    logic [DLY_W-1:0] act_arr  [NUM_CH];
    logic [1:0]       mode_arr [NUM_CH];
    logic [NUM_CH-1:0] path_out;
    logic             armed;
    logic [DLY_W-1:0] rise_act;
    logic [DLY_W-1:0] fall_act;

    assign mode_arr[0] = rise_mode;
    assign mode_arr[1] = fall_mode;

    db_global_arm u_arm (
        .clk         (clk),
        .rst_n       (rst_n),
        .global_req  (global_req),
        .zero_strobe (zero_strobe),
        .armed       (armed)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        db_update_ctl #(.DLY_W(DLY_W)) u_upd (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (wr_en && (wr_sel == 1'(ch))),
            .wr_data     (wr_data),
            .mode        (mode_arr[ch]),
            .zero_strobe (zero_strobe),
            .armed       (armed),
            .act_dly     (act_arr[ch])
        );

        db_edge_path #(.DLY_W(DLY_W), .ACTIVE_HIGH(ch == 0)) u_path (
            .clk    (clk),
            .rst_n  (rst_n),
            .enable (enable),
            .pwm_in (pwm_in),
            .dly    (act_arr[ch]),
            .out    (path_out[ch])
        );
    end

    assign rise_act  = act_arr[0];
    assign fall_act  = act_arr[1];
    assign pwm_a_out = path_out[0];
    assign pwm_b_out = path_out[1];

endmodule

// File: rtl/db_checker.sv
module db_checker #(
    parameter int DLY_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             pwm_in,
    input logic             zero_strobe,
    input logic             wr_en,
    input logic             wr_sel,
    input logic [DLY_W-1:0] wr_data,
    input logic [1:0]       rise_mode,
    input logic             pwm_a_out,
    input logic             pwm_b_out,
    input logic [DLY_W-1:0] rise_act,
    input logic             armed
);

    // R7
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwm_a_out && pwm_b_out));

    // R2
    bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (pwm_a_out == $past(pwm_in)) && (pwm_b_out == !$past(pwm_in)));

    // R4
    a_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_in |=> !pwm_a_out);

    // R5
    b_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_in |=> !pwm_b_out);

    // R8
    imm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && !rise_mode[1]) |=> (rise_act == $past(wr_data)));

    // R9
    hold_until_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!zero_strobe && !(wr_en && !wr_sel && !rise_mode[1])) |=> $stable(rise_act));

    // R10
    global_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_mode == 2'b11 && !armed) |=> $stable(rise_act));

endmodule

bind deadband_gen db_checker #(.DLY_W(DLY_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .pwm_in      (pwm_in),
    .zero_strobe (zero_strobe),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .rise_mode   (rise_mode),
    .pwm_a_out   (pwm_a_out),
    .pwm_b_out   (pwm_b_out),
    .rise_act    (rise_act),
    .armed       (armed)
);

// File: tb/tb_deadband_gen.sv
`timescale 1ns/1ps
module tb_deadband_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        pwm_in = 1'b0;
    logic        zero_strobe = 1'b0;
    logic        global_req = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [11:0] wr_data = '0;
    logic [1:0]  rise_mode = 2'b00;
    logic [1:0]  fall_mode = 2'b00;
    logic        pwm_a_out, pwm_b_out;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    deadband_gen dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .pwm_in(pwm_in),
        .zero_strobe(zero_strobe), .global_req(global_req), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rise_mode(rise_mode),
        .fall_mode(fall_mode), .pwm_a_out(pwm_a_out), .pwm_b_out(pwm_b_out)
    );

    // behavioural reference
    int  m_act [2];
    int  m_shadow [2];
    bit  m_pend [2];
    bit  m_armed;
    int  hi_run, lo_run;
    bit  exp_a, exp_b;
    bit  model_on = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = '{0, 0}; m_shadow = '{0, 0}; m_pend = '{0, 0};
            m_armed = 0; hi_run = 0; lo_run = 0; exp_a = 0; exp_b = 0;
        end else begin
            int mode [2];
            bit old_armed;
            mode[0] = rise_mode; mode[1] = fall_mode;
            old_armed = m_armed;
            if (enable) begin
                exp_a = pwm_in && (hi_run >= m_act[0]);
                exp_b = !pwm_in && (lo_run >= m_act[1]);
            end else begin
                exp_a = pwm_in;
                exp_b = !pwm_in;
            end
            hi_run = pwm_in ? ((hi_run < 4095) ? hi_run + 1 : 4095) : 0;
            lo_run = !pwm_in ? ((lo_run < 4095) ? lo_run + 1 : 4095) : 0;
            for (int c = 0; c < 2; c++) begin
                if (zero_strobe && m_pend[c] &&
                    (mode[c] == 2 || (mode[c] == 3 && old_armed))) begin
                    m_act[c] = m_shadow[c];
                    m_pend[c] = 0;
                end
                if (wr_en && (wr_sel == c[0])) begin
                    if (mode[c] >= 2) begin
                        m_shadow[c] = wr_data; m_pend[c] = 1;
                    end else begin
                        m_act[c] = wr_data; m_shadow[c] = wr_data; m_pend[c] = 0;
                    end
                end
            end
            m_armed = global_req || (old_armed && !zero_strobe);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (model_on) begin
            check(pwm_a_out == exp_a, {cur_req, " pwm_a_out"}, pwm_a_out, exp_a);
            check(pwm_b_out == exp_b, {cur_req, " pwm_b_out"}, pwm_b_out, exp_b);
        end
    end

    // swallow counter for R6
    bit count_on = 0;
    int a_hi_cnt = 0, b_hi_cnt = 0;
    always @(negedge clk) begin
        if (count_on) begin
            if (pwm_a_out) a_hi_cnt++;
            if (pwm_b_out) b_hi_cnt++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pattern(input int hi, input int lo, input int reps);
        for (int r = 0; r < reps; r++) begin
            pwm_in = 1'b1; cyc(hi);
            pwm_in = 1'b0; cyc(lo);
        end
    endtask

    task automatic write_dly(input bit sel, input int val);
        wr_en = 1'b1; wr_sel = sel; wr_data = 12'(val);
        cyc(1);
        wr_en = 1'b0;
    endtask

    task automatic zero_pulse();
        zero_strobe = 1'b1; cyc(1); zero_strobe = 1'b0;
    endtask

    task automatic greq_pulse();
        global_req = 1'b1; cyc(1); global_req = 1'b0;
    endtask

    bit done = 0;

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(3);
        // R1 reset state observed at ports
        check(pwm_a_out == 0, "R1 pwm_a_out in reset", pwm_a_out, 0);
        check(pwm_b_out == 0, "R1 pwm_b_out in reset", pwm_b_out, 0);
        rst_n = 1'b1;
        model_on = 1;
        check(pwm_a_out == 0 && pwm_b_out == 0, "R1 after release", {pwm_a_out, pwm_b_out}, 0);

        // R3 enabled, zero delays
        cur_req = "R3"; enable = 1'b1;
        pattern(4, 3, 4); pattern(1, 1, 4);

        // R8 immediate writes, code 00 rise and 01 fall
        cur_req = "R8"; rise_mode = 2'b00; fall_mode = 2'b01;
        write_dly(1'b0, 5); write_dly(1'b1, 3);
        pattern(12, 9, 3);

        // R2 disabled ignores the loaded delays
        cur_req = "R2"; enable = 1'b0;
        pattern(2, 3, 4); pattern(1, 1, 3);
        enable = 1'b1;

        // R4 and R5 long pulses with delays 5 and 3
        cur_req = "R4"; pattern(20, 2, 2);
        cur_req = "R5"; pattern(2, 15, 2);

        // R6 pulses not longer than the delays vanish
        cur_req = "R6";
        pwm_in = 1'b0; cyc(10);
        pattern(4, 3, 1);
        count_on = 1; pattern(4, 3, 5); count_on = 0;
        check(a_hi_cnt == 0, "R6 pwm_a_out highs", a_hi_cnt, 0);
        check(b_hi_cnt == 0, "R6 pwm_b_out highs", b_hi_cnt, 0);
        a_hi_cnt = 0; b_hi_cnt = 0;
        pattern(6, 4, 1);
        count_on = 1; pattern(6, 4, 3); count_on = 0;
        check(a_hi_cnt == 3, "R6 one-longer high pulses", a_hi_cnt, 3);
        check(b_hi_cnt == 3, "R6 one-longer low pulses", b_hi_cnt, 3);

        // R9 local sync, rewrite replaces the pending value
        cur_req = "R9"; rise_mode = 2'b10; fall_mode = 2'b10;
        write_dly(1'b0, 9); write_dly(1'b0, 1); write_dly(1'b1, 7);
        pattern(12, 12, 2);
        zero_pulse();
        pattern(12, 12, 2);

        // R10 global sync
        cur_req = "R10"; rise_mode = 2'b11; fall_mode = 2'b11;
        write_dly(1'b0, 6); write_dly(1'b1, 2);
        zero_pulse();
        pattern(10, 10, 2);
        greq_pulse();
        pattern(10, 10, 1);
        zero_pulse();
        pattern(10, 10, 2);
        write_dly(1'b0, 2);
        greq_pulse(); zero_pulse();
        write_dly(1'b0, 8);
        zero_pulse();
        pattern(10, 10, 2);
        global_req = 1'b1; zero_strobe = 1'b1; cyc(1);
        global_req = 1'b0; zero_strobe = 1'b0;
        zero_pulse();
        pattern(10, 10, 2);

        // R11 synchronized write on the transfer edge
        cur_req = "R11"; rise_mode = 2'b10;
        write_dly(1'b0, 4);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 12'd10; zero_strobe = 1'b1;
        cyc(1);
        wr_en = 1'b0; zero_strobe = 1'b0;
        pattern(12, 6, 2);
        zero_pulse();
        pattern(14, 6, 2);

        // R7 rapid toggling with mixed delays
        cur_req = "R7"; rise_mode = 2'b00; fall_mode = 2'b00;
        write_dly(1'b0, 0); write_dly(1'b1, 1);
        for (int i = 0; i < 60; i++) begin
            pwm_in = ((i * 7) % 5) > 1;
            cyc(1);
        end

        model_on = 0;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule